// File: doc/BRIEF.md
# Four-State Serial Moore Sequencer

This block is a small synchronous Moore state machine with one serial data input and one output bit. A two-bit state register holds one of four coded states. Each active clock edge moves it to a new state, chosen by a fixed next-state table from the present state and the input bit. When the input is 1 the state steps through an irregular cycle: 00 goes to 11, 11 to 10, 10 to 01, and 01 back to 11. When the input is 0 the state holds, except in state 01, which falls back to 00.

The output is the low bit of the state, so it moves only when the state register moves. It never follows the input between edges. A parameter selects the active clock edge. The default is the falling edge, which gives the input the whole high phase of the clock to settle. The rising edge suits designs that clock everything on one edge. Reset is synchronous and active high. The present state is also brought out so that the controller around the block can decode it.

Top module: `seq4_moore`

## Requirements
- R1: `state_o` shows the present state, coded as 00, 01, 10 and 11. After a reset release it changes only at an active clock edge.
- R2: If `rst` is high at an active clock edge, the state becomes 00 at that edge, whatever the state and input were before.
- R3: From state 00, input 0 keeps the state at 00 and input 1 moves it to 11.
- R4: From state 11, input 0 keeps the state at 11 and input 1 moves it to 10.
- R5: From state 10, input 0 keeps the state at 10 and input 1 moves it to 01.
- R6: From state 01, input 0 moves the state to 00 and input 1 moves it to 11.
- R7: While `rst` is low, `z` equals bit 0 of the present state. It does not change unless the state changes.
- R8: While `rst` is high, `z` is 0. This holds from the moment `rst` rises, before any clock edge.
- R9: When `ACTIVE_FALLING` is 1 (the default), the state and the input sample are taken on the falling edge of `clk`. When it is 0, they are taken on the rising edge. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The active edge is set by `ACTIVE_FALLING`. |
| rst | input | 1 | Synchronous reset, active high. |
| x | input | 1 | Serial data input, sampled at the active edge. |
| z | output | 1 | Moore output: bit 0 of the state, forced to 0 during reset. |
| state_o | output | 2 | Present state code. |

## Verification
The bench builds two copies of the block side by side. One uses the default falling-edge setting and the other uses `ACTIVE_FALLING = 0`. Both are fed the same input stream. Between the falling edge and the next rising edge, the falling-edge copy must already show its new state while the rising-edge copy still holds its old one, which checks R9 directly. Both copies then walk the traced input sequence and all eight (state, input) pairs. Each pair is reached from reset, so the full table is covered for both edge choices.

// File: rtl/seq4_pkg.sv
package seq4_pkg;

   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_HOME  = 2'b00,
      ST_TAIL  = 2'b01,
      ST_SLIDE = 2'b10,
      ST_PEAK  = 2'b11
   } seq_state_e;

endpackage

// File: rtl/seq4_next_logic.sv
module seq4_next_logic
   import seq4_pkg::*;
(
   input  seq_state_e cur_i,
   input  logic       bit_i,
   output seq_state_e nxt_o
);

   always_comb begin
      nxt_o = ST_HOME;
      unique case (cur_i)
         ST_HOME:  nxt_o = bit_i ? ST_PEAK  : ST_HOME;
         ST_PEAK:  nxt_o = bit_i ? ST_SLIDE : ST_PEAK;
         ST_SLIDE: nxt_o = bit_i ? ST_TAIL  : ST_SLIDE;
         ST_TAIL:  nxt_o = bit_i ? ST_PEAK  : ST_HOME;
         default:  nxt_o = ST_HOME;
      endcase
   end

endmodule

// File: rtl/seq4_state_reg.sv
module seq4_state_reg
   import seq4_pkg::*;
#(
   parameter int ACTIVE_FALLING = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  seq_state_e d_i,
   output seq_state_e q_o
);

   if (!(ACTIVE_FALLING inside {0, 1})) begin : g_bad_edge
      $error("seq4_state_reg: ACTIVE_FALLING must be 0 or 1");
   end

   if (ACTIVE_FALLING == 1) begin : g_fall
      always_ff @(negedge clk) begin
         if (rst) q_o <= ST_HOME;
         else     q_o <= d_i;
      end
   end else begin : g_rise
      always_ff @(posedge clk) begin
         if (rst) q_o <= ST_HOME;
         else     q_o <= d_i;
      end
   end

endmodule

// File: rtl/seq4_out_decode.sv
module seq4_out_decode
   import seq4_pkg::*;
(
   input  logic       rst,
   input  seq_state_e cur_i,
   output logic       z_o
);

   logic [STATE_W-1:0] code;

   always_comb begin
      code = cur_i;
      z_o  = code[0] & ~rst;
   end

endmodule

// File: rtl/seq4_moore.sv
module seq4_moore
   import seq4_pkg::*;
#(
   parameter int ACTIVE_FALLING = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               x,
   output logic               z,
   output logic [STATE_W-1:0] state_o
);

   seq_state_e cur_st;
   seq_state_e nxt_st;

   seq4_next_logic u_next (
      .cur_i (cur_st),
      .bit_i (x),
      .nxt_o (nxt_st)
   );

   seq4_state_reg #(
      .ACTIVE_FALLING (ACTIVE_FALLING)
   ) u_reg (
      .clk (clk),
      .rst (rst),
      .d_i (nxt_st),
      .q_o (cur_st)
   );

   seq4_out_decode u_out (
      .rst   (rst),
      .cur_i (cur_st),
      .z_o   (z)
   );

   assign state_o = cur_st;

   // Sampling clock for the checks: follows the chosen active edge.
   logic act_clk;
   assign act_clk = (ACTIVE_FALLING == 1) ? ~clk : clk;

   a_r2_reset_home: assert property (@(posedge act_clk)
      rst |=> state_o == 2'b00);

   a_r3_home_step: assert property (@(posedge act_clk) disable iff (rst)
      state_o == 2'b00 |=> state_o == ($past(x) ? 2'b11 : 2'b00));

   a_r4_peak_step: assert property (@(posedge act_clk) disable iff (rst)
      state_o == 2'b11 |=> state_o == ($past(x) ? 2'b10 : 2'b11));

   a_r5_slide_step: assert property (@(posedge act_clk) disable iff (rst)
      state_o == 2'b10 |=> state_o == ($past(x) ? 2'b01 : 2'b10));

   a_r6_tail_step: assert property (@(posedge act_clk) disable iff (rst)
      state_o == 2'b01 |=> state_o == ($past(x) ? 2'b11 : 2'b00));

   a_r7_z_moore: assert property (@(posedge act_clk) disable iff (rst)
      $stable(state_o) |-> $stable(z));

endmodule

// File: tb/seq4_moore_bench.sv
module seq4_moore_bench;

   logic clk = 1'b0;
   logic rst = 1'b0;
   logic x   = 1'b0;
   logic       z_f, z_r;
   logic [1:0] st_f, st_r;
   logic [1:0] model;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   seq4_moore u_seq4_moore (
      .clk (clk), .rst (rst), .x (x), .z (z_f), .state_o (st_f)
   );

   seq4_moore #(.ACTIVE_FALLING(0)) u_seq4_moore_rise (
      .clk (clk), .rst (rst), .x (x), .z (z_r), .state_o (st_r)
   );

   function automatic logic [1:0] ref_next(input logic [1:0] s, input logic b);
      case (s)
         2'b00:   return b ? 2'b11 : 2'b00;
         2'b11:   return b ? 2'b10 : 2'b11;
         2'b10:   return b ? 2'b01 : 2'b10;
         default: return b ? 2'b11 : 2'b00;
      endcase
   endfunction

   function automatic string req_of(input logic [1:0] s);
      case (s)
         2'b00:   return "R3";
         2'b11:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // Entered at rising edge + 1; returns at rising edge + 1.
   task automatic step(input logic v, input string req);
      logic [1:0] old_s, exp_s;
      old_s = model;
      exp_s = ref_next(old_s, v);
      x = v;
      @(negedge clk); #1;
      chk("R9", "falling copy after falling edge", st_f, exp_s);
      chk("R9", "rising copy before rising edge", st_r, old_s);
      @(posedge clk); #1;
      chk(req, "falling copy state", st_f, exp_s);
      chk(req, "rising copy state", st_r, exp_s);
      chk("R7", "falling copy z", {1'b0, z_f}, {1'b0, exp_s[0]});
      chk("R7", "rising copy z", {1'b0, z_r}, {1'b0, exp_s[0]});
      model = exp_s;
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      rst = 1'b1;
      x   = 1'b0;
      #0.5;
      chk("R8", "z falling copy on reset rise", {1'b0, z_f}, 2'b00);
      chk("R8", "z rising copy on reset rise", {1'b0, z_r}, 2'b00);
      @(negedge clk); #1;
      @(posedge clk); #1;
      chk("R2", "falling copy reset state", st_f, 2'b00);
      chk("R2", "rising copy reset state", st_r, 2'b00);
      chk("R8", "z held low in reset", {z_f, z_r}, 2'b00);
      rst   = 1'b0;
      model = 2'b00;
   endtask

   task automatic t_trace();
      logic       seq [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      logic [1:0] exp [6] = '{2'b11, 2'b11, 2'b10, 2'b10, 2'b01, 2'b00};
      t_reset();
      for (int i = 0; i < 6; i++) begin
         step(seq[i], req_of(model));
         chk("R1", "trace state", st_f, exp[i]);
      end
   endtask

   task automatic t_all_pairs();
      logic [1:0] targets [4] = '{2'b00, 2'b11, 2'b10, 2'b01};
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 2; b++) begin
            t_reset();
            for (int k = 0; k < s; k++) step(1'b1, req_of(model));
            chk("R1", "pair start state", st_f, targets[s]);
            step(logic'(b), req_of(model));
         end
      end
   endtask

   task automatic t_reset_midrun();
      t_reset();
      step(1'b1, "R3");
      step(1'b1, "R4");
      step(1'b1, "R5");
      chk("R7", "z high in state 01", {z_f, z_r}, 2'b11);
      x   = 1'b1;
      rst = 1'b1;
      #0.5;
      chk("R8", "z forced low mid-run", {z_f, z_r}, 2'b00);
      @(negedge clk); #1;
      @(posedge clk); #1;
      chk("R2", "falling copy reset from 01", st_f, 2'b00);
      chk("R2", "rising copy reset from 01", st_r, 2'b00);
      rst   = 1'b0;
      x     = 1'b0;
      model = 2'b00;
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_trace();
      t_all_pairs();
      t_reset_midrun();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule